// File: doc/BRIEF.md
# SD host global register block

This block is the shared register front end for an SD host controller that carries one or two slot engines behind a single 4 KiB memory-mapped window. It decodes a simple 32-bit register bus. The low 256 bytes of the window hold a global register file:

- controller information with slot-presence flags and a self-clearing reset request;
- debounce, bus, write-protect polarity and card-detect words;
- an interrupt status word.

The per-slot capability and maximum-current words sit at fixed global offsets. Each slot engine takes its capability and current values from this block.

Each slot engine owns a 256-byte window that starts at byte offset (n+1)*0x100. For such an access the block only raises a per-slot select line. The slot engine serves the access, and the global file neither stores nor returns anything for it.

Each slot's interrupt line is tracked as a level in the status word. The OR of all status bits drives a single interrupt output.

Top module: `sd_glue_regs`

## Requirements
- R1: After reset the following hold:
  - word 0x00 reads 0x00010000 with one slot, or 0x00030000 with two slots (bit 16 = slot 0 present, bit 17 = slot 1 present);
  - word 0x04 reads 0x00000005;
  - each present slot's capability word reads the parameter `CAP_DEFAULT`;
  - every other word, `irq_o` and `soft_rst_o` are 0.
- R2: A write to offset 0x00 stores bits 31:1 of the write data, and bit 0 always reads back as 0.
- R3: `soft_rst_o` is high for exactly the cycle after each write to offset 0x00 whose data bit 0 is 1, and is low at all other times.
- R4: Offsets 0x10 and 0x18 are slot 0's capability and maximum-current words. Offsets 0x20 and 0x28 are the same words for slot 1. They are readable and writable. Slot n's values appear on bits [32n+31:32n] of `slot_cap_o` and `slot_cur_o` from the cycle after the write.
- R5: Every other word offset below 0x100 except 0xfc (for example bus 0x08, write-protect polarity 0xec, card detect 0xf0) is plain 32-bit read/write storage.
- R6: The status word at 0xfc reads bit n equal to `slot_irq_i[n]` as sampled at the previous clock edge. All its other bits read 0, and writes to it have no effect.
- R7: `irq_o` is high in the cycle after any `slot_irq_i` bit is high, and low in the cycle after all of them are low.
- R8: `rdata_o` shows the addressed word one cycle after `rd_en_i`, with the contents from before any write in that same cycle. It is 0 in any cycle that does not follow a read strobe.
- R9: For byte offsets 0x100 and above, reads return 0 and writes change no global word.
- R10: `slot_sel_o[n]` is high, in the same cycle and without a register, while a read or write strobe is active and the byte address lies in [(n+1)*0x100, (n+2)*0x100). At most one bit is high at a time.
- R11: Address bits 1:0 are ignored, so all accesses are whole 32-bit words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address in the 4 KiB window |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| slot_irq_i | input | NSLOT | Per-slot interrupt levels |
| irq_o | output | 1 | Combined interrupt |
| soft_rst_o | output | 1 | One-cycle controller reset request |
| slot_sel_o | output | NSLOT | Slot window select, one bit per slot |
| slot_cap_o | output | 32*NSLOT | Capability words, slot n at [32n+31:32n] |
| slot_cur_o | output | 32*NSLOT | Maximum-current words, slot n at [32n+31:32n] |

## Verification
The bench drives several interrupt patterns: slot 0 alone, slot 1 alone, both slots, and none. These separate a status word that tracks each slot's own level from one that latches bits or merges the slots. Info writes are issued with bit 0 set and with bit 0 clear, and back to back, so a missing pulse can be told apart from a pulse that stretches or from a stored reset bit. Reads that coincide with writes, reads at out-of-window and slot-window offsets, and addresses with nonzero low bits show whether read data is taken before the write and whether the address decode is exact. Every cycle, all outputs are compared against a behavioural model.

// File: rtl/sd_glue_pkg.sv
package sd_glue_pkg;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned IDX_INFO      = 0;
  localparam int unsigned IDX_DEBOUNCE  = 1;
  localparam int unsigned IDX_CAP0      = 4;   // 0x10
  localparam int unsigned IDX_CUR0      = 6;   // 0x18
  localparam int unsigned SLOT_IDX_STEP = 4;   // 0x10 bytes between slots
  localparam int unsigned PRESENT_BIT   = 16;
  localparam logic [WORD_W-1:0] DEBOUNCE_RST = 32'h0000_0005;

  function automatic logic [WORD_W-1:0] word_reset(input int unsigned idx,
                                                   input int unsigned nslot,
                                                   input logic [WORD_W-1:0] cap);
    logic [WORD_W-1:0] v;
    v = '0;
    if (idx == IDX_INFO) begin
      for (int unsigned s = 0; s < nslot; s++) v[PRESENT_BIT+s] = 1'b1;
    end else if (idx == IDX_DEBOUNCE) begin
      v = DEBOUNCE_RST;
    end else begin
      for (int unsigned s = 0; s < nslot; s++)
        if (idx == IDX_CAP0 + SLOT_IDX_STEP*s) v = cap;
    end
    return v;
  endfunction
endpackage

// File: rtl/sd_glue_decode.sv
module sd_glue_decode #(
  parameter int unsigned AW          = 12,
  parameter int unsigned NSLOT       = 2,
  parameter int unsigned FILE_BYTES  = 256,
  parameter int unsigned SLOT_STRIDE = 256,
  localparam int unsigned IW = $clog2(FILE_BYTES/4),
  localparam int unsigned SW = $clog2(SLOT_STRIDE)
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic             rd_en_i,
  output logic             in_file_o,
  output logic [IW-1:0]    idx_o,
  output logic [NSLOT-1:0] slot_sel_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  assign in_file_o = (addr_i < AW'(FILE_BYTES));
  assign idx_o     = addr_i[IW+1:2];

  for (genvar n = 0; n < NSLOT; n++) begin : g_sel
    assign slot_sel_o[n] = (wr_en_i | rd_en_i) && (addr_i[AW-1:SW] == (AW-SW)'(n+1));
  end
endmodule

// File: rtl/sd_glue_irq.sv
module sd_glue_irq #(
  parameter int unsigned NSLOT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSLOT-1:0] slot_irq_i,
  output logic [NSLOT-1:0] stat_o,
  output logic             irq_o
);
  logic [NSLOT-1:0] stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= slot_irq_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;
endmodule

// File: rtl/sd_glue_regfile.sv
module sd_glue_regfile
  import sd_glue_pkg::*;
#(
  parameter int unsigned NSLOT       = 2,
  parameter int unsigned FILE_BYTES  = 256,
  parameter logic [31:0] CAP_DEFAULT = 32'h0127_30B2,
  localparam int unsigned WORDS    = FILE_BYTES/4,
  localparam int unsigned IW       = $clog2(WORDS),
  localparam int unsigned IDX_STAT = WORDS-1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [IW-1:0]           idx_i,
  input  logic [WORD_W-1:0]       wdata_i,
  input  logic [NSLOT-1:0]        stat_i,
  output logic [WORD_W-1:0]       rd_word_o,
  output logic                    soft_rst_o,
  output logic [NSLOT*WORD_W-1:0] cap_o,
  output logic [NSLOT*WORD_W-1:0] cur_o
);
  logic [WORD_W-1:0] mem_q [WORDS];
  logic              srst_q;

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [WORD_W-1:0] RST = word_reset(g, NSLOT, CAP_DEFAULT);
    if (g == IDX_STAT) begin : g_stat
      // status lives in the irq collector; slot kept constant
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[g] <= '0;
        else         mem_q[g] <= '0;
      end
    end else if (g == IDX_INFO) begin : g_info
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          mem_q[g] <= RST;
        else if (we_i && idx_i == IW'(g))     mem_q[g] <= {wdata_i[WORD_W-1:1], 1'b0};
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                          mem_q[g] <= RST;
        else if (we_i && idx_i == IW'(g))     mem_q[g] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) srst_q <= 1'b0;
    else         srst_q <= we_i && (idx_i == IW'(IDX_INFO)) && wdata_i[0];
  end

  assign rd_word_o  = (idx_i == IW'(IDX_STAT)) ? WORD_W'(stat_i) : mem_q[idx_i];
  assign soft_rst_o = srst_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign cap_o[WORD_W*s +: WORD_W] = mem_q[IDX_CAP0 + SLOT_IDX_STEP*s];
    assign cur_o[WORD_W*s +: WORD_W] = mem_q[IDX_CUR0 + SLOT_IDX_STEP*s];
  end

  logic unused_stat_word;
  assign unused_stat_word = ^mem_q[IDX_STAT];
endmodule

// File: rtl/sd_glue_regs.sv
module sd_glue_regs
  import sd_glue_pkg::*;
#(
  parameter int unsigned NSLOT       = 2,
  parameter int unsigned AW          = 12,
  parameter int unsigned FILE_BYTES  = 256,
  parameter int unsigned SLOT_STRIDE = 256,
  parameter logic [31:0] CAP_DEFAULT = 32'h0127_30B2,
  localparam int unsigned IW = $clog2(FILE_BYTES/4)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [AW-1:0]           addr_i,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [WORD_W-1:0]       wdata_i,
  output logic [WORD_W-1:0]       rdata_o,
  input  logic [NSLOT-1:0]        slot_irq_i,
  output logic                    irq_o,
  output logic                    soft_rst_o,
  output logic [NSLOT-1:0]        slot_sel_o,
  output logic [NSLOT*WORD_W-1:0] slot_cap_o,
  output logic [NSLOT*WORD_W-1:0] slot_cur_o
);
  logic              in_file;
  logic [IW-1:0]     idx;
  logic [NSLOT-1:0]  stat;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_q;

  sd_glue_decode #(
    .AW(AW), .NSLOT(NSLOT), .FILE_BYTES(FILE_BYTES), .SLOT_STRIDE(SLOT_STRIDE)
  ) u_dec (
    .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .in_file_o(in_file), .idx_o(idx), .slot_sel_o(slot_sel_o)
  );

  sd_glue_irq #(.NSLOT(NSLOT)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .slot_irq_i(slot_irq_i),
    .stat_o(stat), .irq_o(irq_o)
  );

  sd_glue_regfile #(
    .NSLOT(NSLOT), .FILE_BYTES(FILE_BYTES), .CAP_DEFAULT(CAP_DEFAULT)
  ) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_en_i && in_file), .idx_i(idx),
    .wdata_i(wdata_i), .stat_i(stat), .rd_word_o(rd_word),
    .soft_rst_o(soft_rst_o), .cap_o(slot_cap_o), .cur_o(slot_cur_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rdata_q <= '0;
    else if (rd_en_i && in_file) rdata_q <= rd_word;
    else                        rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sd_glue_regs_chk.sv
module sd_glue_regs_chk #(
  parameter int unsigned NSLOT = 2,
  parameter int unsigned AW    = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic [NSLOT-1:0] slot_irq_i,
  input logic             irq_o,
  input logic             soft_rst_o,
  input logic [NSLOT-1:0] slot_sel_o
);
  // R3
  srst_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[AW-1:2] == '0 && wdata_i[0]) |=> soft_rst_o);
  // R3
  srst_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_en_i && addr_i[AW-1:2] == '0 && wdata_i[0])) |=> !soft_rst_o);
  // R7
  irq_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|slot_irq_i) |=> irq_o);
  // R7
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|slot_irq_i)) |=> !irq_o);
  // R8
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rdata_o == '0));
  // R2
  info_bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[AW-1:2] == '0) |=> !rdata_o[0]);
  // R9
  oor_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[AW-1:8] != '0) |=> (rdata_o == '0));
  // R10
  sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_sel_o));
  // R10
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !rd_en_i) |-> (slot_sel_o == '0));
endmodule

bind sd_glue_regs sd_glue_regs_chk #(.NSLOT(NSLOT), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .slot_irq_i(slot_irq_i), .irq_o(irq_o), .soft_rst_o(soft_rst_o),
  .slot_sel_o(slot_sel_o)
);

// File: tb/sd_glue_regs_test.sv
`timescale 1ns/1ps
module sd_glue_regs_test;
  localparam int NSLOT = 2;
  localparam logic [31:0] CAP = 32'h0127_30B2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [11:0]       addr = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NSLOT-1:0]  sirq = '0;
  logic              irq, srst;
  logic [NSLOT-1:0]  sel;
  logic [NSLOT*32-1:0] cap, cur;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  sd_glue_regs #(.NSLOT(NSLOT), .CAP_DEFAULT(CAP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .slot_irq_i(sirq), .irq_o(irq),
    .soft_rst_o(srst), .slot_sel_o(sel), .slot_cap_o(cap), .slot_cur_o(cur)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [31:0]      m_file [64];
  logic [NSLOT-1:0] m_stat;
  logic [31:0]      e_rd;
  logic             e_srst;

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a >= 12'h100) return 32'h0;
    if (a[7:2] == 6'd63) return 32'(m_stat);
    return m_file[a[7:2]];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) m_file[i] = 32'h0;
      m_file[0] = (NSLOT == 2) ? 32'h0003_0000 : 32'h0001_0000;
      m_file[1] = 32'h5;
      m_file[4] = CAP;
      if (NSLOT == 2) m_file[8] = CAP;
      m_stat = '0; e_rd = '0; e_srst = 1'b0;
    end else begin
      e_rd   = rd ? m_read(addr) : 32'h0;
      e_srst = wr && addr < 12'h100 && addr[7:2] == 6'd0 && wdata[0];
      if (wr && addr < 12'h100 && addr[7:2] != 6'd63)
        m_file[addr[7:2]] = (addr[7:2] == 6'd0) ? {wdata[31:1], 1'b0} : wdata;
      m_stat = sirq;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(rdata == e_rd, {cur_tag, " R8 rdata"}, 64'(rdata), 64'(e_rd));
      chk(irq == (|m_stat), "R7 irq", 64'(irq), 64'(|m_stat));
      chk(srst == e_srst, "R3 soft_rst", 64'(srst), 64'(e_srst));
      for (int s = 0; s < NSLOT; s++) begin
        chk(cap[32*s +: 32] == m_file[4+4*s], "R4 cap out", 64'(cap[32*s +: 32]), 64'(m_file[4+4*s]));
        chk(cur[32*s +: 32] == m_file[6+4*s], "R4 cur out", 64'(cur[32*s +: 32]), 64'(m_file[6+4*s]));
      end
    end
  end

  task automatic bus(input bit w, input bit r, input logic [11:0] a, input logic [31:0] d);
    logic [NSLOT-1:0] exp_sel;
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    #1;
    for (int n = 0; n < NSLOT; n++) exp_sel[n] = (w | r) && (a[11:8] == 4'(n+1));
    chk(sel == exp_sel, "R10 slot_sel", 64'(sel), 64'(exp_sel));
  endtask

  task automatic idle();
    @(negedge clk);
    wr = 0; rd = 0;
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus(0, 1, a, 32'h0);
    @(negedge clk);
    #1;
    chk(rdata == exp, tag, 64'(rdata), 64'(exp));
    wr = 0; rd = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(irq == 1'b0, "R1 irq reset", 64'(irq), 64'h0);
    chk(srst == 1'b0, "R1 srst reset", 64'(srst), 64'h0);
    chk(rdata == 32'h0, "R1 rdata reset", 64'(rdata), 64'h0);
    cur_tag = "R1";
    rd_expect(12'h000, 32'h0003_0000, "R1 info");
    rd_expect(12'h004, 32'h0000_0005, "R1 debounce");
    rd_expect(12'h008, 32'h0, "R1 bus");
    rd_expect(12'h010, CAP, "R1 cap0");
    rd_expect(12'h020, CAP, "R1 cap1");
    rd_expect(12'h018, 32'h0, "R1 cur0");
    rd_expect(12'h0fc, 32'h0, "R1 status");

    cur_tag = "R2";
    bus(1, 0, 12'h000, 32'hA5A5_0003); idle();
    rd_expect(12'h000, 32'hA5A5_0002, "R2 info bit0");
    cur_tag = "R3";
    bus(1, 0, 12'h000, 32'h0003_0000);
    bus(1, 0, 12'h000, 32'h0003_0001);
    bus(1, 0, 12'h000, 32'h0003_0001);
    idle(); idle();
    rd_expect(12'h000, 32'h0003_0000, "R3 info after pulses");

    cur_tag = "R4";
    bus(1, 0, 12'h010, 32'h1111_0010);
    bus(1, 0, 12'h018, 32'h2222_0018);
    bus(1, 0, 12'h020, 32'h3333_0020);
    bus(1, 0, 12'h028, 32'h4444_0028); idle();
    rd_expect(12'h010, 32'h1111_0010, "R4 cap0");
    rd_expect(12'h028, 32'h4444_0028, "R4 cur1");
    chk(cap == {32'h3333_0020, 32'h1111_0010}, "R4 cap bus", cap, {32'h3333_0020, 32'h1111_0010});
    chk(cur == {32'h4444_0028, 32'h2222_0018}, "R4 cur bus", cur, {32'h4444_0028, 32'h2222_0018});

    cur_tag = "R5";
    bus(1, 0, 12'h008, 32'hDEAD_0008);
    bus(1, 0, 12'h0ec, 32'hBEEF_00EC);
    bus(1, 0, 12'h0f0, 32'hCAFE_00F0);
    bus(1, 0, 12'h040, 32'h0BAD_0040); idle();
    rd_expect(12'h008, 32'hDEAD_0008, "R5 bus word");
    rd_expect(12'h0ec, 32'hBEEF_00EC, "R5 wp pol");
    rd_expect(12'h0f0, 32'hCAFE_00F0, "R5 card det");
    rd_expect(12'h040, 32'h0BAD_0040, "R5 spare");

    cur_tag = "R6";
    @(negedge clk) sirq = 2'b01;
    rd_expect(12'h0fc, 32'h1, "R6 slot0 irq");
    @(negedge clk) sirq = 2'b10;
    rd_expect(12'h0fc, 32'h2, "R6 slot1 irq");
    @(negedge clk) sirq = 2'b11;
    bus(1, 0, 12'h0fc, 32'hFFFF_FFFF); idle();
    rd_expect(12'h0fc, 32'h3, "R6 both, write ignored");
    chk(irq == 1'b1, "R7 irq high", 64'(irq), 64'h1);
    @(negedge clk) sirq = 2'b00;
    rd_expect(12'h0fc, 32'h0, "R6 none");
    chk(irq == 1'b0, "R7 irq low", 64'(irq), 64'h0);

    cur_tag = "R8";
    bus(1, 0, 12'h008, 32'h0000_0011);
    bus(1, 1, 12'h008, 32'h0000_0022);
    @(negedge clk); #1;
    chk(rdata == 32'h11, "R8 read before write", 64'(rdata), 64'h11);
    wr = 0; rd = 0;
    rd_expect(12'h008, 32'h22, "R8 write landed");

    cur_tag = "R9";
    bus(1, 0, 12'h104, 32'h9999_9999);
    bus(1, 0, 12'h208, 32'h8888_8888);
    bus(1, 0, 12'h3fc, 32'h7777_7777); idle();
    rd_expect(12'h104, 32'h0, "R9 slot0 window read");
    rd_expect(12'h308, 32'h0, "R9 beyond slots read");
    rd_expect(12'h004, 32'h5, "R9 debounce untouched");
    rd_expect(12'h008, 32'h22, "R9 bus untouched");

    cur_tag = "R10";
    bus(0, 1, 12'h1f0, 32'h0);
    bus(1, 0, 12'h200, 32'h0);
    bus(0, 1, 12'h2ff, 32'h0);
    bus(0, 0, 12'h150, 32'h0); idle();

    cur_tag = "R11";
    bus(1, 0, 12'h0ef, 32'h5A5A_1234); idle();
    rd_expect(12'h0ec, 32'h5A5A_1234, "R11 low bits ignored");
    rd_expect(12'h0ed, 32'h5A5A_1234, "R11 odd read");

    repeat (3) idle();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule